// File: doc/BRIEF.md
# Locked SMM Memory Window Controller

This block holds the control byte for the legacy 128 KB system-management memory window at A0000h–BFFFFh. It also decides, for each memory access, whether that window is served from DRAM or passed downstream. Software programs the byte through a small configuration write/read port. Each access presents its address, an SMM-mode flag and a code/data flag, and the block answers with a single route bit: 1 sends the access to DRAM at the unchanged address, 0 forwards it downstream.

The control byte has a global enable, an open bit, a closed bit and a lock bit. Once the lock bit is written, the block clears the open bit at the same moment. The enable, the lock and the extended-segment settings then become read-only until a full reset. The closed bit stays writable after lock. A second configuration byte carries the enable and size of the extended SMM segment. That segment is not decoded here; its byte exists so that the lock can freeze it.

Top module: `smm_window_ctrl`

## Requirements
- R1: After a full reset, the control byte at offset 9Dh reads 8'h02 and the extended byte at offset 9Eh reads 8'h00.
- R2: The control byte layout is bit 7 reserved (reads 0), bit 6 open, bit 5 closed, bit 4 lock, bit 3 global enable, and bits 2:0 a read-only base segment that always reads 3'b010. Any offset other than 9Dh or 9Eh reads 0 and ignores writes.
- R3: While unlocked, a write to 9Dh loads bits 6:3 from the write data. The new value is visible on the read port and on the route decision in the cycle after the write is accepted.
- R4: A write to 9Dh with bit 4 set sets lock and leaves open at 0, whatever bit 6 of the same write holds.
- R5: Once set, lock stays set until a full reset.
- R6: While locked, writes leave open, lock and global enable unchanged, and also the extended byte, but a write to 9Dh still updates the closed bit.
- R7: An access whose address lies outside A0000h–BFFFFh is always forwarded (route 0).
- R8: With global enable 0, every access is forwarded, whatever the open, closed and lock bits hold.
- R9: With global enable 1, an SMM-mode access in the window goes to DRAM unless closed is 1 and the access is a data access. An SMM-mode code fetch reaches DRAM even when closed is 1.
- R10: With global enable 1, a non-SMM access in the window goes to DRAM only when open is 1 and lock is 0. This also holds when closed is also 1.
- R11: The extended byte at 9Eh holds the enable in bit 0 and the size in bits 2:1, reads 0 in bits 7:3, drives the outputs ext_seg_en and ext_seg_size, and while unlocked takes effect in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| acc_addr | input | 32 | Access address |
| acc_smm | input | 1 | Access issued in SMM mode |
| acc_code | input | 1 | 1 for a code fetch, 0 for a data access |
| route_dram | output | 1 | 1 routes the access to DRAM, 0 forwards it downstream |
| ext_seg_en | output | 1 | Extended segment enable field |
| ext_seg_size | output | 2 | Extended segment size field |

## Verification
On every cycle the assertions check several properties of the lock and the decode. The lock never drops, and a lock write always leaves open at 0. While locked, the enable and the extended fields hold still. Out-of-window addresses, a cleared enable, and SMM data accesses with closed set all yield a forward. Only the bench's scenarios can show the ordering effects. These include a write taking hold exactly one cycle later, the closed bit staying writable while everything else is frozen, and the priority between open and closed across both modes. They also cover the exact window edges at 9FFFFh, A0000h, BFFFFh and C0000h.

// File: rtl/smmw_pkg.sv
package smmw_pkg;

  // Writable control state of the compatible-window byte
  typedef struct packed {
    logic open;
    logic closed;
    logic lock;
    logic gen;
  } smm_ctl_t;

  // Hardwired base segment: selects A0000h..BFFFFh
  localparam logic [2:0] BASE_SEG = 3'b010;

endpackage

// File: rtl/smmw_cfg_regs.sv
module smmw_cfg_regs
  import smmw_pkg::*;
#(
  parameter int              CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] SMM_OFS = 8'h9D,
  parameter logic [CFG_AW-1:0] EXT_OFS = 8'h9E,
  parameter int              EXT_SZ_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output smm_ctl_t          ctl,
  output logic              ext_en,
  output logic [EXT_SZ_W-1:0] ext_size,
  output logic [7:0]        cfg_rdata
);

  localparam int EXT_BITS = EXT_SZ_W + 1;

  logic hit_smm, hit_ext;
  logic unused_wd;

  assign hit_smm   = (cfg_addr == SMM_OFS);
  assign hit_ext   = (cfg_addr == EXT_OFS);
  assign unused_wd = cfg_wdata[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      ext_en   <= 1'b0;
      ext_size <= '0;
    end else if (cfg_we) begin
      if (hit_smm) begin
        ctl.closed <= cfg_wdata[5];
        if (!ctl.lock) begin
          ctl.gen  <= cfg_wdata[3];
          ctl.lock <= cfg_wdata[4];
          ctl.open <= cfg_wdata[6] & ~cfg_wdata[4];
        end
      end
      if (hit_ext && !ctl.lock) begin
        ext_en   <= cfg_wdata[0];
        ext_size <= cfg_wdata[EXT_SZ_W:1];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit_smm) begin
      cfg_rdata = {1'b0, ctl.open, ctl.closed, ctl.lock, ctl.gen, BASE_SEG};
    end else if (hit_ext) begin
      cfg_rdata[EXT_BITS-1:0] = {ext_size, ext_en};
    end
  end

endmodule

// File: rtl/smmw_decode.sv
module smmw_decode
  import smmw_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                WIN_LOG2 = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_code,
  input  smm_ctl_t          ctl,
  output logic              route_dram
);

  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic in_win, open_eff, unused_lo;

  assign in_win    = (acc_addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
  assign open_eff  = ctl.open & ~ctl.lock;
  assign unused_lo = ^acc_addr[WIN_LOG2-1:0];

  always_comb begin
    route_dram = 1'b0;
    if (in_win && ctl.gen) begin
      if (acc_smm) route_dram = acc_code | ~ctl.closed;
      else         route_dram = open_eff;
    end
  end

endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl
  import smmw_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                CFG_AW   = 8,
  parameter int                EXT_SZ_W = 2,
  parameter int                WIN_LOG2 = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter logic [CFG_AW-1:0] SMM_OFS  = 8'h9D,
  parameter logic [CFG_AW-1:0] EXT_OFS  = 8'h9E
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic                acc_smm,
  input  logic                acc_code,
  output logic                route_dram,
  output logic                ext_seg_en,
  output logic [EXT_SZ_W-1:0] ext_seg_size
);

  smm_ctl_t ctl_q;

  smmw_cfg_regs #(
    .CFG_AW(CFG_AW), .SMM_OFS(SMM_OFS), .EXT_OFS(EXT_OFS), .EXT_SZ_W(EXT_SZ_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctl(ctl_q), .ext_en(ext_seg_en),
    .ext_size(ext_seg_size), .cfg_rdata(cfg_rdata)
  );

  smmw_decode #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_code(acc_code),
    .ctl(ctl_q), .route_dram(route_dram)
  );

endmodule

// File: rtl/smmw_checker.sv
module smmw_checker #(
  parameter int                ADDR_W   = 32,
  parameter int                CFG_AW   = 8,
  parameter int                EXT_SZ_W = 2,
  parameter int                WIN_LOG2 = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter logic [CFG_AW-1:0] SMM_OFS  = 8'h9D
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_we,
  input logic [CFG_AW-1:0]   cfg_addr,
  input logic [7:0]          cfg_wdata,
  input logic [7:0]          cfg_rdata,
  input logic [ADDR_W-1:0]   acc_addr,
  input logic                acc_smm,
  input logic                acc_code,
  input logic                route_dram,
  input logic                ext_en,
  input logic [EXT_SZ_W-1:0] ext_size,
  input logic                open,
  input logic                closed,
  input logic                lock,
  input logic                gen
);

  logic outside;
  assign outside = (acc_addr[ADDR_W-1:WIN_LOG2] != WIN_BASE[ADDR_W-1:WIN_LOG2]);

  a_r2_fixed_fields: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == SMM_OFS) |-> (cfg_rdata[7] == 1'b0 && cfg_rdata[2:0] == 3'b010));

  a_r4_lock_clears_open: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == SMM_OFS && cfg_wdata[4]) |=> (lock && !open));

  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    lock |=> ($stable(gen) && $stable(ext_en) && $stable(ext_size) && !open));

  a_r7_outside_fwd: assert property (@(posedge clk) disable iff (rst)
    outside |-> !route_dram);

  a_r8_gen_off_fwd: assert property (@(posedge clk) disable iff (rst)
    !gen |-> !route_dram);

  a_r9_closed_data: assert property (@(posedge clk) disable iff (rst)
    (acc_smm && !acc_code && closed) |-> !route_dram);

endmodule

bind smm_window_ctrl smmw_checker #(
  .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .EXT_SZ_W(EXT_SZ_W),
  .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE), .SMM_OFS(SMM_OFS)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
  .acc_smm(acc_smm), .acc_code(acc_code), .route_dram(route_dram),
  .ext_en(ext_seg_en), .ext_size(ext_seg_size), .open(ctl_q.open),
  .closed(ctl_q.closed), .lock(ctl_q.lock), .gen(ctl_q.gen)
);

// File: tb/tb_smm_window_ctrl.sv
module tb_smm_window_ctrl;

  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic [31:0] acc_addr = 0;
  logic        acc_smm = 0;
  logic        acc_code = 0;
  logic        route_dram;
  logic        ext_seg_en;
  logic [1:0]  ext_seg_size;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // behavioural reference state
  bit m_open, m_cls, m_lck, m_gen, m_xen;
  bit [1:0] m_xsz;

  always #(CLK_P/2) clk = ~clk;

  smm_window_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
    .acc_smm(acc_smm), .acc_code(acc_code), .route_dram(route_dram),
    .ext_seg_en(ext_seg_en), .ext_seg_size(ext_seg_size)
  );

  function automatic bit [7:0] exp_rd(bit [7:0] a);
    if (a == 8'h9D) return {1'b0, m_open, m_cls, m_lck, m_gen, 3'b010};
    if (a == 8'h9E) return {5'b0, m_xsz, m_xen};
    return 8'h00;
  endfunction

  function automatic bit exp_route(bit [31:0] a, bit smm, bit code);
    if (a < 32'hA0000 || a > 32'hBFFFF) return 0;
    if (!m_gen) return 0;
    if (smm) return code || !m_cls;
    return m_open && !m_lck;
  endfunction

  task automatic model_reset();
    m_open = 0; m_cls = 0; m_lck = 0; m_gen = 0; m_xen = 0; m_xsz = 0;
  endtask

  task automatic model_write(bit [7:0] a, bit [7:0] d);
    if (a == 8'h9D) begin
      m_cls = d[5];
      if (!m_lck) begin
        m_gen = d[3]; m_lck = d[4]; m_open = d[6] && !d[4];
      end
    end else if (a == 8'h9E && !m_lck) begin
      m_xen = d[0]; m_xsz = d[2:1];
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit we, bit [7:0] a, bit [7:0] d, bit [31:0] ad,
                      bit smm, bit code, string req);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    acc_addr = ad; acc_smm = smm; acc_code = code;
    #1;
    check(cfg_rdata == exp_rd(a), req, "rdata", cfg_rdata, exp_rd(a));
    check(route_dram == exp_route(ad, smm, code), req, "route",
          route_dram, exp_route(ad, smm, code));
    check({ext_seg_size, ext_seg_en} == {m_xsz, m_xen}, req, "ext",
          {ext_seg_size, ext_seg_en}, {m_xsz, m_xen});
    @(posedge clk);
    if (we) model_write(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; cfg_we = 0;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset values, R8 enable off
    step(0, 8'h9D, 0, 32'hA0000, 1, 0, "R1");
    step(0, 8'h9E, 0, 32'hB0000, 1, 1, "R1");
    // R2 other offsets read 0 and ignore writes
    step(1, 8'h10, 8'hFF, 32'hA0000, 1, 0, "R2");
    step(0, 8'h9D, 0, 32'hA0000, 0, 0, "R2");
    // R3 enable; visible next cycle
    step(1, 8'h9D, 8'h08, 32'hA0000, 1, 0, "R3");
    step(0, 8'h9D, 0, 32'hA0000, 1, 0, "R3");
    // R7 window edges
    step(0, 8'h9D, 0, 32'h9FFFF, 1, 0, "R7");
    step(0, 8'h9D, 0, 32'hBFFFF, 1, 0, "R7");
    step(0, 8'h9D, 0, 32'hC0000, 1, 1, "R7");
    step(0, 8'h9D, 0, 32'h100A0000, 1, 1, "R7");
    // R10 non-SMM without open
    step(0, 8'h9D, 0, 32'hA8000, 0, 0, "R10");
    // R9 closed: data blocked, code passes
    step(1, 8'h9D, 8'h28, 32'hA0000, 1, 0, "R9");
    step(0, 8'h9D, 0, 32'hA0000, 1, 0, "R9");
    step(0, 8'h9D, 0, 32'hA0000, 1, 1, "R9");
    // R10 open, and open+closed out of SMM
    step(1, 8'h9D, 8'h48, 32'hA0000, 0, 0, "R10");
    step(0, 8'h9D, 0, 32'hA0000, 0, 0, "R10");
    step(1, 8'h9D, 8'h68, 32'hB1234, 0, 0, "R10");
    step(0, 8'h9D, 0, 32'hB1234, 0, 0, "R10");
    step(0, 8'h9D, 0, 32'hB1234, 1, 0, "R9");
    // R8 enable off with open set
    step(1, 8'h9D, 8'h40, 32'hA0000, 0, 0, "R8");
    step(0, 8'h9D, 0, 32'hA0000, 0, 0, "R8");
    step(0, 8'h9D, 0, 32'hA0000, 1, 1, "R8");
    // R11 extended byte
    step(1, 8'h9E, 8'hFF, 32'hA0000, 0, 0, "R11");
    step(0, 8'h9E, 0, 32'hA0000, 0, 0, "R11");
    step(1, 8'h9E, 8'h04, 32'hA0000, 0, 0, "R11");
    step(0, 8'h9E, 0, 32'hA0000, 0, 0, "R11");
    // R4 lock with open requested: open stays 0
    step(1, 8'h9D, 8'h58, 32'hA0000, 0, 0, "R4");
    step(0, 8'h9D, 0, 32'hA0000, 0, 0, "R4");
    step(0, 8'h9D, 0, 32'hA0000, 1, 0, "R4");
    // R6 frozen fields, closed still writable
    step(1, 8'h9D, 8'h40, 32'hA0000, 0, 0, "R6");
    step(0, 8'h9D, 0, 32'hA0000, 0, 0, "R6");
    step(1, 8'h9D, 8'h20, 32'hA0000, 1, 0, "R6");
    step(0, 8'h9D, 0, 32'hA0000, 1, 0, "R6");
    step(0, 8'h9D, 0, 32'hA0000, 1, 1, "R6");
    step(1, 8'h9E, 8'h03, 32'hA0000, 0, 0, "R6");
    step(0, 8'h9E, 0, 32'hA0000, 0, 0, "R6");
    // R5 lock sticky against a zero write
    step(1, 8'h9D, 8'h00, 32'hA0000, 1, 0, "R5");
    step(0, 8'h9D, 0, 32'hA0000, 1, 0, "R5");
    // R1 full reset clears lock
    do_reset();
    step(0, 8'h9D, 0, 32'hA0000, 1, 0, "R1");
    step(0, 8'h9E, 0, 32'hA0000, 1, 0, "R1");
    step(1, 8'h9D, 8'h48, 32'hA0000, 0, 0, "R5");
    step(0, 8'h9D, 0, 32'hA0000, 0, 0, "R5");
    @(negedge clk); cfg_we = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule